// File: doc/BRIEF.md
# Syndrome Weight Threshold Unit

This unit measures how many bits of a 36-bit parity syndrome are set and decides whether that count is small enough for the decoder stage it serves. It is meant for a cyclic block-code decoder whose codeword has 73 bits, 37 of which carry the message. Every search stage of that decoder asks the same question with a different limit, so one circuit serves all of them. A 2-bit check code, presented with each syndrome, selects the limit.

The count is formed in two registered steps. In the first step the syndrome is cut into six 6-bit slices, and each slice is reduced to a 3-bit partial count. In the second step the six partial counts are added into a 6-bit weight, and that weight is compared with the limit for the check code that travelled down the pipeline with the syndrome. A new syndrome can enter on every clock. The weight and the pass flag appear exactly two clocks later and stay unchanged until the next valid result.

Top module: `syndrome_weight_unit`

## Requirements
- R1: While reset is held and directly after it, `res_valid` is 0, `res_weight` is 0 and `res_pass` is 0.
- R2: For an accepted syndrome, `res_weight` equals the number of 1 bits in that syndrome (0 to 36).
- R3: The check code selects the weight limit: 0 (initial check) allows weight up to 6, 1 (single-error check) up to 5, 2 (two-error check) up to 4, and 3 (three-error check) up to 3. `res_pass` is 1 only when the weight is at or below the selected limit.
- R4: Syndromes may be presented on consecutive clocks with a different check code each time. Each result uses the code that arrived with its own syndrome, and no idle cycle is inserted.
- R5: An all-zero syndrome gives weight 0 and `res_pass` = 1 under every check code.
- R6: An all-ones syndrome gives weight 36 and `res_pass` = 0 under every check code.
- R7: `res_valid` is 1 exactly two clocks after `syn_valid` was sampled as 1, and 0 otherwise. Syndrome and code values presented while `syn_valid` is 0 have no effect: `res_weight` and `res_pass` keep their last values.
- R8: A weight exactly equal to the selected limit passes, and a weight one above the limit fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| syn_valid | input | 1 | Syndrome and check code are presented this cycle |
| syn_bits | input | 36 | Syndrome vector |
| chk_code | input | 2 | Check code: 0 initial, 1 single, 2 two, 3 three errors |
| res_valid | output | 1 | Result of a syndrome sampled two clocks earlier |
| res_weight | output | 6 | Hamming weight of that syndrome |
| res_pass | output | 1 | Weight is within the limit of its check code |

## Verification
A corrupt partial count in the first step appears at the ports two clocks later as a wrong weight, and it also flips the pass flag for any weight near a limit. A check code that falls out of step with its syndrome only shows up when neighbouring codes differ. The bench therefore streams items whose code changes on every clock and sweeps every weight from 0 to 36 under all four codes. A broken valid chain shows up as a missing or extra result, or as a latency other than two clocks. A register that updates while no syndrome is accepted shows up as a changed weight during idle cycles.

// File: rtl/swu_pkg.sv
package swu_pkg;

    typedef enum logic [1:0] {
        CHK_INITIAL = 2'd0,
        CHK_SINGLE  = 2'd1,
        CHK_DOUBLE  = 2'd2,
        CHK_TRIPLE  = 2'd3
    } chk_mode_e;

endpackage

// File: rtl/swu_slice_count.sv
module swu_slice_count #(
    parameter int SLICE_W = 6,
    parameter int CNT_W   = 3
) (
    input  logic [SLICE_W-1:0] slice_bits,
    output logic [CNT_W-1:0]   slice_count
);

    always_comb begin
        slice_count = '0;
        for (int i = 0; i < SLICE_W; i++) begin
            slice_count = slice_count + CNT_W'(slice_bits[i]);
        end
    end

endmodule

// File: rtl/swu_partial_stage.sv
module swu_partial_stage
    import swu_pkg::*;
#(
    parameter int SYN_W  = 36,
    parameter int SLICES = 6,
    localparam int SLICE_W = SYN_W / SLICES,
    localparam int CNT_W   = $clog2(SLICE_W + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [SYN_W-1:0]          in_syndrome,
    input  chk_mode_e                 in_mode,
    output logic                      s1_valid,
    output logic [SLICES*CNT_W-1:0]   s1_parts,
    output chk_mode_e                 s1_mode
);

    logic [SLICES*CNT_W-1:0] part_comb;

    for (genvar g = 0; g < SLICES; g++) begin : g_slice
        swu_slice_count #(
            .SLICE_W(SLICE_W),
            .CNT_W  (CNT_W)
        ) u_cnt (
            .slice_bits (in_syndrome[g*SLICE_W +: SLICE_W]),
            .slice_count(part_comb[g*CNT_W +: CNT_W])
        );

        assert_part_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
            s1_valid |-> (s1_parts[g*CNT_W +: CNT_W] <= CNT_W'(SLICE_W)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_parts <= '0;
            s1_mode  <= CHK_INITIAL;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_parts <= part_comb;
                s1_mode  <= in_mode;
            end
        end
    end

endmodule

// File: rtl/swu_sum_stage.sv
module swu_sum_stage
    import swu_pkg::*;
#(
    parameter int SYN_W   = 36,
    parameter int SLICES  = 6,
    parameter int MAX_ERR = 6,
    localparam int SLICE_W = SYN_W / SLICES,
    localparam int CNT_W   = $clog2(SLICE_W + 1),
    localparam int WGT_W   = $clog2(SYN_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s1_valid,
    input  logic [SLICES*CNT_W-1:0] s1_parts,
    input  chk_mode_e               s1_mode,
    output logic                    out_valid,
    output logic [WGT_W-1:0]        out_weight,
    output logic                    out_pass
);

    logic [WGT_W-1:0] total;
    logic [WGT_W-1:0] limit;

    always_comb begin
        total = '0;
        for (int i = 0; i < SLICES; i++) begin
            total = total + WGT_W'(s1_parts[i*CNT_W +: CNT_W]);
        end
    end

    always_comb begin
        unique case (s1_mode)
            CHK_INITIAL: limit = WGT_W'(MAX_ERR);
            CHK_SINGLE:  limit = WGT_W'(MAX_ERR - 1);
            CHK_DOUBLE:  limit = WGT_W'(MAX_ERR - 2);
            CHK_TRIPLE:  limit = WGT_W'(MAX_ERR - 3);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_weight <= '0;
            out_pass   <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_weight <= total;
                out_pass   <= (total <= limit);
            end
        end
    end

    assert_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);
    assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !out_valid);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> ($stable(out_weight) && $stable(out_pass)));
    assert_weight_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_weight <= WGT_W'(SYN_W)));
    assert_zero_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_weight == '0) |-> out_pass);
    assert_heavy_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_weight > WGT_W'(MAX_ERR)) |-> !out_pass);

endmodule

// File: rtl/syndrome_weight_unit.sv
module syndrome_weight_unit
    import swu_pkg::*;
#(
    parameter int SYN_W   = 36,
    parameter int SLICES  = 6,
    parameter int MAX_ERR = 6,
    localparam int SLICE_W = SYN_W / SLICES,
    localparam int CNT_W   = $clog2(SLICE_W + 1),
    localparam int WGT_W   = $clog2(SYN_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             syn_valid,
    input  logic [SYN_W-1:0] syn_bits,
    input  logic [1:0]       chk_code,
    output logic             res_valid,
    output logic [WGT_W-1:0] res_weight,
    output logic             res_pass
);

    logic                    s1_valid;
    logic [SLICES*CNT_W-1:0] s1_parts;
    chk_mode_e               s1_mode;

    swu_partial_stage #(
        .SYN_W (SYN_W),
        .SLICES(SLICES)
    ) u_partial (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (syn_valid),
        .in_syndrome(syn_bits),
        .in_mode    (chk_mode_e'(chk_code)),
        .s1_valid   (s1_valid),
        .s1_parts   (s1_parts),
        .s1_mode    (s1_mode)
    );

    swu_sum_stage #(
        .SYN_W  (SYN_W),
        .SLICES (SLICES),
        .MAX_ERR(MAX_ERR)
    ) u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_parts  (s1_parts),
        .s1_mode   (s1_mode),
        .out_valid (res_valid),
        .out_weight(res_weight),
        .out_pass  (res_pass)
    );

    assert_code_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
        syn_valid |-> !$isunknown(chk_code));

endmodule

// File: tb/syndrome_weight_unit_test.sv
module syndrome_weight_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int SYN_W      = 36;
    localparam int MAX_ERR    = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              syn_valid = 1'b0;
    logic [SYN_W-1:0]  syn_bits = '0;
    logic [1:0]        chk_code = 2'd0;
    logic              res_valid;
    logic [5:0]        res_weight;
    logic              res_pass;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int exp_w[$];
    int exp_p[$];
    int exp_c[$];
    int exp_t[$];
    int last_t;
    bit monitor_on = 1'b0;

    syndrome_weight_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .syn_valid (syn_valid),
        .syn_bits  (syn_bits),
        .chk_code  (chk_code),
        .res_valid (res_valid),
        .res_weight(res_weight),
        .res_pass  (res_pass)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic logic [SYN_W-1:0] make_syn(input int w, input int seed);
        logic [SYN_W-1:0] v = '0;
        for (int j = 0; j < SYN_W; j++) begin
            if (((j * 7 + seed) % SYN_W) < w) v[j] = 1'b1;
        end
        return v;
    endfunction

    task automatic send(input int w, input int code, input int seed);
        @(negedge clk);
        syn_valid = 1'b1;
        syn_bits  = make_syn(w, seed);
        chk_code  = 2'(code);
        exp_w.push_back(w);
        exp_p.push_back((w <= MAX_ERR - code) ? 1 : 0);
        exp_c.push_back(code);
        exp_t.push_back(cyc);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            syn_valid = 1'b0;
            syn_bits  = make_syn((k * 5) % 37, k);
            chk_code  = 2'(k);
        end
    endtask

    // Monitor: sample a quarter period after each rising edge.
    always begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (monitor_on && res_valid) begin
            if (exp_w.size() == 0) begin
                check("R7 unexpected result", 1, 0);
            end else begin
                int w, p, c, t, lim;
                string tag;
                w = exp_w.pop_front();
                p = exp_p.pop_front();
                c = exp_c.pop_front();
                t = exp_t.pop_front();
                lim = MAX_ERR - c;
                check("R7 latency", cyc - t, 2);
                check("R2 weight", int'(res_weight), w);
                if (w == 0)                        tag = "R5 zero pass";
                else if (w == SYN_W)               tag = "R6 full fail";
                else if (w == lim || w == lim + 1) tag = "R8 limit edge";
                else                               tag = "R3 pass flag";
                check(tag, int'(res_pass), p);
                if (last_t == t - 1) check("R4 back-to-back mode", int'(res_pass), p);
                last_t = t;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        report();
    end

    initial begin
        logic [5:0] hold_w;
        logic       hold_p;
        last_t = -10;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", int'(res_valid), 0);
        check("R1 reset weight", int'(res_weight), 0);
        check("R1 reset pass", int'(res_pass), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset valid", int'(res_valid), 0);
        monitor_on = 1'b1;

        // Sweep every weight under every code, code changing each clock (R2 R3 R4 R8).
        for (int w = 0; w <= SYN_W; w++) begin
            for (int c = 0; c < 4; c++) begin
                send(w, c, w + c * 3);
            end
        end
        idle(4);

        // Zero and full syndromes under each code (R5 R6).
        for (int c = 0; c < 4; c++) send(0, c, c);
        for (int c = 0; c < 4; c++) send(SYN_W, c, c);
        idle(4);

        // Sparse stream with gaps (R7).
        for (int i = 0; i < 12; i++) begin
            send((i * 11) % 37, i % 4, i);
            idle(i % 3);
        end
        idle(4);

        // Inputs without valid must not disturb outputs (R7).
        @(negedge clk);
        hold_w = res_weight;
        hold_p = res_pass;
        idle(6);
        @(negedge clk);
        check("R7 idle valid", int'(res_valid), 0);
        check("R7 idle weight hold", int'(res_weight), int'(hold_w));
        check("R7 idle pass hold", int'(res_pass), int'(hold_p));
        check("R7 all results seen", exp_w.size(), 0);
        report();
    end

endmodule